// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This execute-stage unit decides whether an immediate-form trap instruction fires. It accepts one 32-bit instruction word per cycle, along with the program counter of that instruction and the 64-bit value already read from the addressed general-purpose register. It sign-extends the 16-bit immediate and evaluates five comparisons: signed less/greater, equality, and unsigned less/greater. A 5-bit condition mask taken from the instruction chooses which of those comparisons can raise a trap.

The word form compares only the low half of the register. The doubleword form compares all 64 bits. One registered stage then presents four results: the trap request, the next program counter, the exception vector together with a saved-status trap flag, and a typed-trap code. The typed-trap code is used by handlers that dispatch on the immediate of an unconditional word trap. The unit writes no architectural register.

Top module: `trap_eval_unit`

## Requirements
- R1: `outValid` equals `inValid` delayed by one clock. While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: The primary opcode is `instrWord[31:26]`. Value 3 selects the word form and value 2 selects the doubleword form. Any other opcode gives `trapReq`=0 and `nextPc`=`curPc`+4.
- R3: The word form compares `regValue[31:0]` against the immediate `instrWord[15:0]` sign-extended to 32 bits. `regValue[63:32]` has no effect on the outcome.
- R4: The mask is `instrWord[25:21]`, read as a 5-bit value. Weight 16 selects signed less-than, 8 signed greater-than, 4 equal, 2 unsigned less-than and 1 unsigned greater-than, all with the register as the left operand. A trap fires when any selected condition holds.
- R5: For either trap form, mask 31 always traps and mask 0 never traps.
- R6: The combined masks behave as expected: 24 traps on not-equal, 20 on signed less-or-equal, 12 on signed greater-or-equal, 5 on unsigned greater-or-equal and 6 on unsigned less-or-equal.
- R7: On a trap, `nextPc` is the unchanged `curPc`, `excVector` is 0x700 and `statusTrapFlag` is 1. Otherwise `nextPc` is `curPc`+4, `excVector` is 0 and `statusTrapFlag` is 0.
- R8: `typedValid` is set, with `typedCode` equal to the raw `instrWord[15:0]`, only when a word-form trap fires with mask 31 and RA field `instrWord[20:16]` equal to 0. In every other case both outputs are 0.
- R9: The doubleword form compares all 64 bits of `regValue` against the immediate sign-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and instruction are present this cycle |
| instrWord | input | 32 | Instruction word |
| curPc | input | PC_W (64) | Address of the instruction |
| regValue | input | 64 | Value of the register named by the RA field |
| outValid | output | 1 | Registered result is present |
| trapReq | output | 1 | Trap request |
| nextPc | output | PC_W (64) | Faulting address on a trap, otherwise the sequential address |
| excVector | output | PC_W (64) | Interrupt vector when trapping, otherwise zero |
| statusTrapFlag | output | 1 | Trap indication for the saved machine status |
| typedValid | output | 1 | Typed-trap code is present |
| typedCode | output | 16 | Raw immediate of a typed trap |

## Verification
The assertions assume `rst` is held high for at least one edge before any result is trusted. They also assume `curPc`, `instrWord` and `regValue` are stable and meaningful whenever `inValid` is high. Properties on the next-PC arithmetic compare against the `curPc` sampled on the capture edge. The bench drives every input on the falling edge and raises `inValid` only after reset has been released. Each instruction is held for exactly one capture edge with a fresh `curPc`, so the assumptions hold throughout.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int REG_W   = 64;
  localparam int WORD_W  = 32;
  localparam int IMM_W   = 16;
  localparam int INSTR_W = 32;
  localparam int MASK_W  = 5;
  localparam int RA_W    = 5;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_WORD_IMM  = 6'd3;
  localparam logic [OPC_W-1:0] OPC_DWORD_IMM = 6'd2;

  // condition bit positions inside the mask (value weights 1..16)
  localparam int C_UGT = 0;
  localparam int C_ULT = 1;
  localparam int C_EQ  = 2;
  localparam int C_SGT = 3;
  localparam int C_SLT = 4;

  typedef struct packed {
    logic              capture;
    logic              evalEn;
    logic              wideCmp;
    logic [MASK_W-1:0] condMask;
    logic              typedCand;
  } trapStrobes_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output trapStrobes_t       strobes,
  output logic [IMM_W-1:0]   immField,
  output logic               outValid
);
  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int MASK_LSB = OPC_LSB - MASK_W;
  localparam int RA_LSB   = MASK_LSB - RA_W;

  logic [OPC_W-1:0]  opcField;
  logic [MASK_W-1:0] maskField;
  logic [RA_W-1:0]   raField;
  logic              isWord;
  logic              isDword;

  assign opcField  = instrWord[INSTR_W-1:OPC_LSB];
  assign maskField = instrWord[OPC_LSB-1:MASK_LSB];
  assign raField   = instrWord[MASK_LSB-1:RA_LSB];
  assign immField  = instrWord[IMM_W-1:0];

  assign isWord  = (opcField == OPC_WORD_IMM);
  assign isDword = (opcField == OPC_DWORD_IMM);

  always_comb begin
    strobes.capture   = inValid;
    strobes.evalEn    = isWord | isDword;
    strobes.wideCmp   = isDword;
    strobes.condMask  = maskField;
    strobes.typedCand = isWord && (&maskField) && (raField == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int                PC_W        = 64,
  parameter logic [PC_W-1:0]   TRAP_VECTOR = 'h700
) (
  input  logic              clk,
  input  logic              rst,
  input  trapStrobes_t      strobes,
  input  logic [IMM_W-1:0]  immField,
  input  logic [REG_W-1:0]  regValue,
  input  logic [PC_W-1:0]   curPc,
  output logic              trapReq,
  output logic [PC_W-1:0]   nextPc,
  output logic [PC_W-1:0]   excVector,
  output logic              statusTrapFlag,
  output logic              typedValid,
  output logic [IMM_W-1:0]  typedCode
);
  localparam int HI_W = REG_W - WORD_W;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic [REG_W-1:0]  immWide;
  logic [REG_W-1:0]  sA, sB, uA, uB;
  logic [MASK_W-1:0] condHold;
  logic              fire;

  assign immWide = {{(REG_W-IMM_W){immField[IMM_W-1]}}, immField};

  // word form: sign-extend low halves for signed, zero-extend for unsigned
  always_comb begin
    if (strobes.wideCmp) begin
      sA = regValue;
      sB = immWide;
      uA = regValue;
      uB = immWide;
    end else begin
      sA = {{HI_W{regValue[WORD_W-1]}}, regValue[WORD_W-1:0]};
      sB = immWide;
      uA = {{HI_W{1'b0}}, regValue[WORD_W-1:0]};
      uB = {{HI_W{1'b0}}, immWide[WORD_W-1:0]};
    end
  end

  always_comb begin
    condHold        = '0;
    condHold[C_SLT] = $signed(sA) < $signed(sB);
    condHold[C_SGT] = $signed(sA) > $signed(sB);
    condHold[C_EQ]  = (uA == uB);
    condHold[C_ULT] = uA < uB;
    condHold[C_UGT] = uA > uB;
  end

  assign fire = strobes.evalEn && |(condHold & strobes.condMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      trapReq        <= 1'b0;
      nextPc         <= '0;
      excVector      <= '0;
      statusTrapFlag <= 1'b0;
      typedValid     <= 1'b0;
      typedCode      <= '0;
    end else if (strobes.capture) begin
      trapReq        <= fire;
      nextPc         <= fire ? curPc : curPc + PC_STEP;
      excVector      <= fire ? TRAP_VECTOR : '0;
      statusTrapFlag <= fire;
      typedValid     <= fire && strobes.typedCand;
      typedCode      <= (fire && strobes.typedCand) ? immField : '0;
    end
  end
endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit
  import trap_pkg::*;
#(
  parameter int              PC_W        = 64,
  parameter logic [PC_W-1:0] TRAP_VECTOR = 'h700
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [PC_W-1:0]    curPc,
  input  logic [REG_W-1:0]   regValue,
  output logic               outValid,
  output logic               trapReq,
  output logic [PC_W-1:0]    nextPc,
  output logic [PC_W-1:0]    excVector,
  output logic               statusTrapFlag,
  output logic               typedValid,
  output logic [IMM_W-1:0]   typedCode
);
  trapStrobes_t     strobes;
  logic [IMM_W-1:0] immField;

  trap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .strobes(strobes), .immField(immField), .outValid(outValid)
  );

  trap_datapath #(.PC_W(PC_W), .TRAP_VECTOR(TRAP_VECTOR)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .immField(immField),
    .regValue(regValue), .curPc(curPc), .trapReq(trapReq), .nextPc(nextPc),
    .excVector(excVector), .statusTrapFlag(statusTrapFlag),
    .typedValid(typedValid), .typedCode(typedCode)
  );
endmodule

// File: rtl/trap_eval_checker.sv
module trap_eval_checker
  import trap_pkg::*;
#(
  parameter int              PC_W        = 64,
  parameter logic [PC_W-1:0] TRAP_VECTOR = 'h700
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic [PC_W-1:0]    curPc,
  input logic [REG_W-1:0]   regValue,
  input logic               outValid,
  input logic               trapReq,
  input logic [PC_W-1:0]    nextPc,
  input logic [PC_W-1:0]    excVector,
  input logic               statusTrapFlag,
  input logic               typedValid,
  input logic [IMM_W-1:0]   typedCode
);
  logic [5:0] opc;
  logic [4:0] msk;
  assign opc = instrWord[31:26];
  assign msk = instrWord[25:21];

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && !trapReq && !typedValid && !statusTrapFlag));
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outValid == $past(inValid)));
  a_r2_other_opcode: assert property (@(posedge clk) disable iff (rst)
    (inValid && opc != 6'd2 && opc != 6'd3) |=> !trapReq);
  a_r5_all_mask: assert property (@(posedge clk) disable iff (rst)
    (inValid && (opc == 6'd2 || opc == 6'd3) && msk == 5'd31) |=> trapReq);
  a_r5_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (inValid && msk == 5'd0) |=> !trapReq);
  a_r7_next_pc: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (nextPc == (trapReq ? $past(curPc) : $past(curPc) + PC_W'(4))));
  a_r7_vector_on_trap: assert property (@(posedge clk) disable iff (rst)
    (outValid && trapReq) |-> (excVector == TRAP_VECTOR && statusTrapFlag));
  a_r7_quiet_no_trap: assert property (@(posedge clk) disable iff (rst)
    (outValid && !trapReq) |-> (excVector == '0 && !statusTrapFlag));
  a_r8_typed_needs_trap: assert property (@(posedge clk) disable iff (rst)
    typedValid |-> trapReq);
  a_r8_typed_code_zero: assert property (@(posedge clk) disable iff (rst)
    !typedValid |-> (typedCode == '0));
endmodule

bind trap_eval_unit trap_eval_checker #(.PC_W(PC_W), .TRAP_VECTOR(TRAP_VECTOR)) u_chk (.*);

// File: tb/trap_eval_unit_tb.sv
module trap_eval_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] instrWord;
  logic [63:0] curPc;
  logic [63:0] regValue;
  logic        outValid, trapReq, statusTrapFlag, typedValid;
  logic [63:0] nextPc, excVector;
  logic [15:0] typedCode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  trap_eval_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .curPc(curPc), .regValue(regValue), .outValid(outValid), .trapReq(trapReq),
    .nextPc(nextPc), .excVector(excVector), .statusTrapFlag(statusTrapFlag),
    .typedValid(typedValid), .typedCode(typedCode)
  );

  function automatic logic [31:0] mk(input int op, input int to, input int ra, input logic [15:0] imm);
    mk = {op[5:0], to[4:0], ra[4:0], imm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] rv;
    logic        expTrap;
    logic        expTyped;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{mk(3, 4, 1, 16'h0005), 64'h5, 1'b1, 1'b0, 4'd4},
    '{mk(3, 4, 1, 16'h0006), 64'h5, 1'b0, 1'b0, 4'd4},
    '{mk(3,16, 1, 16'h0000), 64'hFFFF_FFFF, 1'b1, 1'b0, 4'd4},
    '{mk(3, 2, 1, 16'h0000), 64'hFFFF_FFFF, 1'b0, 1'b0, 4'd4},
    '{mk(3, 1, 1, 16'h0000), 64'hFFFF_FFFF, 1'b1, 1'b0, 4'd4},
    '{mk(3, 8, 1, 16'h0000), 64'hFFFF_FFFF, 1'b0, 1'b0, 4'd4},
    '{mk(3, 4, 2, 16'h0007), 64'hDEAD_BEEF_0000_0007, 1'b1, 1'b0, 4'd3},
    '{mk(3, 4, 2, 16'hFFFF), 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 4'd3},
    '{mk(3,16, 2, 16'h0000), 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 4'd3},
    '{mk(3,24, 3, 16'h0003), 64'h3, 1'b0, 1'b0, 4'd6},
    '{mk(3,24, 3, 16'h0004), 64'h3, 1'b1, 1'b0, 4'd6},
    '{mk(3,20, 3, 16'h0004), 64'h4, 1'b1, 1'b0, 4'd6},
    '{mk(3,20, 3, 16'h0004), 64'h5, 1'b0, 1'b0, 4'd6},
    '{mk(3,12, 3, 16'h0000), 64'h8000_0000, 1'b0, 1'b0, 4'd6},
    '{mk(3, 5, 3, 16'h0000), 64'h8000_0000, 1'b1, 1'b0, 4'd6},
    '{mk(3, 6, 3, 16'h0000), 64'h8000_0000, 1'b0, 1'b0, 4'd6},
    '{mk(3, 6, 3, 16'hFFFF), 64'h2, 1'b1, 1'b0, 4'd6},
    '{mk(3,31, 3, 16'h4321), 64'h77, 1'b1, 1'b0, 4'd5},
    '{mk(3, 0, 0, 16'h0000), 64'h0, 1'b0, 1'b0, 4'd5},
    '{mk(3,31, 0, 16'h1234), 64'h9, 1'b1, 1'b1, 4'd8},
    '{mk(2, 4, 1, 16'h0007), 64'hDEAD_BEEF_0000_0007, 1'b0, 1'b0, 4'd9},
    '{mk(2, 4, 1, 16'hFFFF), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd9},
    '{mk(2,16, 1, 16'h0000), 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 4'd9},
    '{mk(2,31, 0, 16'hABCD), 64'h0, 1'b1, 1'b0, 4'd8},
    '{mk(31,31,0, 16'h0000), 64'h0, 1'b0, 1'b0, 4'd2},
    '{mk(4,31, 0, 16'h0001), 64'h1, 1'b0, 1'b0, 4'd2}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd2: tagName = "R2";
      4'd3: tagName = "R3";
      4'd4: tagName = "R4";
      4'd5: tagName = "R5";
      4'd6: tagName = "R6";
      4'd8: tagName = "R8";
      default: tagName = "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one instruction, then sample after its capture edge
  task automatic issue(input logic [31:0] ins, input logic [63:0] rv, input logic [63:0] pc);
    @(negedge clk);
    instrWord = ins; regValue = rv; curPc = pc; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; inValid = 1'b1; instrWord = mk(3, 31, 0, 16'h5555);
    curPc = 64'h40; regValue = '0;
    repeat (3) @(negedge clk);
    // R1: reset clears every output despite inValid high
    check(!outValid && !trapReq && !typedValid && !statusTrapFlag, "R1", {60'd0, outValid, trapReq, typedValid, statusTrapFlag}, 64'd0);
    check(nextPc == 64'd0 && excVector == 64'd0 && typedCode == 16'd0, "R1", nextPc | excVector, 64'd0);
    inValid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R1", {63'd0, outValid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] pc;
      logic [63:0] expPc;
      pc = 64'h1000 + 64'(i) * 64'h10;
      issue(TBL[i].ins, TBL[i].rv, pc);
      expPc = TBL[i].expTrap ? pc : pc + 64'd4;
      check(outValid, "R1", {63'd0, outValid}, 64'd1);
      check(trapReq == TBL[i].expTrap, tagName(TBL[i].tag), {63'd0, trapReq}, {63'd0, TBL[i].expTrap});
      check(nextPc == expPc, "R7", nextPc, expPc);
      check(excVector == (TBL[i].expTrap ? 64'h700 : 64'h0) && statusTrapFlag == TBL[i].expTrap,
            "R7", excVector, TBL[i].expTrap ? 64'h700 : 64'h0);
      check(typedValid == TBL[i].expTyped && typedCode == (TBL[i].expTyped ? TBL[i].ins[15:0] : 16'h0),
            "R8", {47'd0, typedValid, typedCode}, {47'd0, TBL[i].expTyped, TBL[i].expTyped ? TBL[i].ins[15:0] : 16'h0});
    end

    // R1: valid drops one cycle after the input goes idle
    @(negedge clk);
    check(!outValid, "R1", {63'd0, outValid}, 64'd0);

    // R1: reset in the middle of traffic clears outputs
    issue(mk(3, 31, 0, 16'h00FF), 64'h0, 64'h2000);
    rst = 1'b1;
    @(negedge clk);
    check(!trapReq && !typedValid && typedCode == 16'h0, "R1", {47'd0, typedValid, typedCode}, 64'd0);
    rst = 1'b0;

    // R7: PC wrap at the top of the address space on a non-trap
    issue(mk(3, 0, 1, 16'h0), 64'h0, 64'hFFFF_FFFF_FFFF_FFFC);
    check(nextPc == 64'h0, "R7", nextPc, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule